// File: doc/BRIEF.md
# In-system flash programming controller

This block lets software running on the chip erase, program or read its own flash through six byte-wide registers: a command port, a control register, a mode register, two address bytes and a data byte. An operation starts only when the command port receives a fixed two-byte unlock sequence while the enable bit is set. The CPU is then held for a number of machine cycles that depends on both the operation type and a wait code. The wait code is chosen to suit the system clock frequency. When the operation ends, its effect becomes visible and the CPU resumes.

Reading the command port returns one byte of a two-byte device identifier. The control register also carries a self-clearing software reset request and a boot-source select. The enable bit and the boot-source select are cleared only by the power-up reset, never by the software reset. The flash array is a small behavioural byte memory inside the block. One clock is one machine cycle.

Top module: `isp_flash_ctl`

## Requirements
- R1: Power-up reset (`por_n` low) clears every register to 0, drops `cpu_hold` and `sys_rst`, and leaves every flash byte at FFh.
- R2: Register selects are 0 command, 1 control, 2 mode, 3 address high, 4 address low, 5 data. The unlock logic looks only at command writes. 46h always moves it to its armed step. B9h while armed fires the operation and disarms it. Any other value disarms it. Writes to other registers leave the armed step alone.
- R3: A read of select 0 returns F0h when bit 0 of the address-low register is 0, and 02h when it is 1.
- R4: The control register keeps bit 7 (enable), bit 6 (boot select), bit 5 (software reset request) and bits 2:0 (wait code). Bits 4:3 read 0. Selects 6 and 7 read 0.
- R5: If the enable bit is 0 when B9h fires, no hold occurs and the flash is unchanged.
- R6: `cpu_hold` is high for exactly N cycles from the cycle after the B9h write. Wait codes 0/1/2/3 give N = 43769/21885/10942/5471 for erase, 240/120/60/30 for program and 43/22/11/6 for read. Codes 4 to 7 act as code 3.
- R7: Mode bits 2:0 select the operation: 001 copies the flash byte into the data register, 010 writes the data register to the flash byte, and 011 sets the aligned 16-byte page to FFh. Any other code does nothing and gives no hold. Mode bits 7:3 read 0. The flash address is {address-high bit 0, address-low}, and address-high bits 7:1 read 0.
- R8: Writing control with bit 5 set raises `sys_rst` for exactly the next cycle. Control bit 5 reads 1 only in that cycle. At its end, the mode, address, data, wait code and unlock step are cleared.
- R9: The enable and boot-select bits keep their value through the software reset. `boot_isp` follows the boot-select bit.
- R10: Writes made while `cpu_hold` is high are ignored. The data register and flash change only at the end of the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| cpu_hold | output | 1 | CPU stall while a flash operation runs |
| sys_rst | output | 1 | One-cycle software system reset pulse |
| boot_isp | output | 1 | Boot source: 1 for the ISP memory area |

## Verification
Some internal faults show up on the next clock. A lost or stale unlock step shows up there as a hold that starts or fails to start. A wrong stall count shows up as a hold edge that comes early or late. Other faults surface only when a register is read or when an operation ends. A software reset that clears too much changes the control read-back and `boot_isp` on the cycle after its pulse. A wrong page or address decode stays hidden until a later read operation loads the data register, so reads of untouched neighbouring addresses follow every erase and program.

// File: rtl/isp_flash_ctl.sv
module isp_flash_ctl #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [2:0] sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       cpu_hold,
  output logic       sys_rst,
  output logic       boot_isp
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAGE  = 1 << PAGE_W;
  localparam logic [7:0] KEY_A = 8'h46;
  localparam logic [7:0] KEY_B = 8'hB9;
  localparam logic [2:0] OP_RD = 3'd1, OP_PG = 3'd2, OP_ER = 3'd3;

  logic            en_q, boot_q, swr_q, armed_q;
  logic [2:0]      wc_q, mode_q;
  logic [HI_W-1:0] ah_q;
  logic [7:0]      al_q, dat_q;
  logic [15:0]     cnt_q, len;
  logic [7:0]      mem [DEPTH];
  logic [ADDR_W-1:0] faddr;

  assign faddr    = {ah_q, al_q};
  assign cpu_hold = (cnt_q != 16'd0);
  assign sys_rst  = swr_q;
  assign boot_isp = boot_q;

  always_comb begin
    logic [1:0] w;
    w = wc_q[2] ? 2'd3 : wc_q[1:0];
    len = 16'd0;
    case (mode_q)
      OP_RD: case (w) 2'd0: len = 16'd43;    2'd1: len = 16'd22;
                      2'd2: len = 16'd11;    default: len = 16'd6;    endcase
      OP_PG: case (w) 2'd0: len = 16'd240;   2'd1: len = 16'd120;
                      2'd2: len = 16'd60;    default: len = 16'd30;   endcase
      OP_ER: case (w) 2'd0: len = 16'd43769; 2'd1: len = 16'd21885;
                      2'd2: len = 16'd10942; default: len = 16'd5471; endcase
      default: len = 16'd0;
    endcase
  end

  always_comb begin
    case (sel)
      3'd0: rd_data = al_q[0] ? 8'h02 : 8'hF0;
      3'd1: rd_data = {en_q, boot_q, swr_q, 2'b00, wc_q};
      3'd2: rd_data = {5'd0, mode_q};
      3'd3: rd_data = {{(8-HI_W){1'b0}}, ah_q};
      3'd4: rd_data = al_q;
      3'd5: rd_data = dat_q;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q <= 1'b0; boot_q <= 1'b0; swr_q <= 1'b0; armed_q <= 1'b0;
      wc_q <= '0; mode_q <= '0; ah_q <= '0; al_q <= '0; dat_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (swr_q) begin
      swr_q <= 1'b0; armed_q <= 1'b0;
      wc_q <= '0; mode_q <= '0; ah_q <= '0; al_q <= '0; dat_q <= '0;
    end else if (cpu_hold) begin
      cnt_q <= cnt_q - 16'd1;
      if (cnt_q == 16'd1) begin
        case (mode_q)
          OP_RD: dat_q <= mem[faddr];
          OP_PG: mem[faddr] <= dat_q;
          OP_ER: for (int i = 0; i < PAGE; i++)
                   mem[{faddr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= 8'hFF;
          default: ;
        endcase
      end
    end else if (wr_en) begin
      case (sel)
        3'd0: begin
          armed_q <= (wr_data == KEY_A);
          if (wr_data == KEY_B && armed_q && en_q) cnt_q <= len;
        end
        3'd1: begin
          en_q <= wr_data[7]; boot_q <= wr_data[6];
          swr_q <= wr_data[5]; wc_q <= wr_data[2:0];
        end
        3'd2: mode_q <= wr_data[2:0];
        3'd3: ah_q <= wr_data[HI_W-1:0];
        3'd4: al_q <= wr_data;
        3'd5: dat_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R8
  swrst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !sys_rst);
  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> (en_q == $past(en_q) && boot_isp == $past(boot_isp)));
  // R5
  hold_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_hold) |-> en_q);
  // R6
  hold_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cnt_q > 16'd1) |=> cpu_hold);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    cpu_hold |=> ($stable(mode_q) && $stable(al_q) && $stable(wc_q) && $stable(en_q)));
  // R3
  devid_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sel == 3'd0) |-> (rd_data == 8'hF0 || rd_data == 8'h02));
endmodule

// File: tb/sim_isp_flash_ctl.sv
module sim_isp_flash_ctl;
  localparam int PER = 10;
  logic clk = 1'b0, por_n = 1'b0, wr_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic cpu_hold, sys_rst, boot_isp;
  int checks = 0, fails = 0, cyc = 0;

  always #(PER/2) clk = ~clk;

  isp_flash_ctl u0 (.clk(clk), .por_n(por_n), .sel(sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_hold(cpu_hold),
    .sys_rst(sys_rst), .boot_isp(boot_isp));

  // behavioural reference
  int m_en, m_boot, m_swr, m_arm, m_wc, m_mode, m_ah, m_al, m_dat, m_cnt;
  int mem [512];
  int t_er[4] = '{43769, 21885, 10942, 5471};
  int t_pg[4] = '{240, 120, 60, 30};
  int t_rd[4] = '{43, 22, 11, 6};

  function automatic int op_len();
    int w = (m_wc > 3) ? 3 : m_wc;
    if (m_mode == 1) return t_rd[w];
    if (m_mode == 2) return t_pg[w];
    if (m_mode == 3) return t_er[w];
    return 0;
  endfunction

  function automatic int exp_rd(int s);
    case (s)
      0: return (m_al % 2) ? 8'h02 : 8'hF0;
      1: return m_en * 128 + m_boot * 64 + m_swr * 32 + m_wc;
      2: return m_mode;
      3: return m_ah;
      4: return m_al;
      5: return m_dat;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a;
    a = m_ah * 256 + m_al;
    if (!por_n) begin
      m_en = 0; m_boot = 0; m_swr = 0; m_arm = 0; m_wc = 0; m_mode = 0;
      m_ah = 0; m_al = 0; m_dat = 0; m_cnt = 0;
      for (int i = 0; i < 512; i++) mem[i] = 255;
    end else if (m_swr != 0) begin
      m_swr = 0; m_arm = 0; m_wc = 0; m_mode = 0; m_ah = 0; m_al = 0; m_dat = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        if (m_mode == 1) m_dat = mem[a];
        else if (m_mode == 2) mem[a] = m_dat;
        else if (m_mode == 3)
          for (int i = 0; i < 16; i++) mem[(a / 16) * 16 + i] = 255;
      end
    end else if (wr_en) begin
      case (sel)
        3'd0: begin
          if (wr_data == 8'hB9 && m_arm == 1 && m_en == 1) m_cnt = op_len();
          m_arm = (wr_data == 8'h46) ? 1 : 0;
        end
        3'd1: begin
          m_en = wr_data[7]; m_boot = wr_data[6]; m_swr = wr_data[5];
          m_wc = wr_data[2:0];
        end
        3'd2: m_mode = wr_data[2:0];
        3'd3: m_ah = wr_data[0];
        3'd4: m_al = wr_data;
        3'd5: m_dat = wr_data;
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (por_n) begin
      chk(cpu_hold == (m_cnt > 0), "R6 hold", cpu_hold, m_cnt > 0);
      chk(sys_rst == m_swr[0], "R8 sys_rst", sys_rst, m_swr);
      chk(boot_isp == m_boot[0], "R9 boot", boot_isp, m_boot);
      chk(rd_data == 8'(exp_rd(sel)), "R4 readback", rd_data, exp_rd(sel));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] s, input logic [7:0] e, input string tag);
    @(negedge clk); sel = s; wr_en = 1'b0;
    #1 chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic count_hold(output int n);
    n = 0;
    #1;
    while (cpu_hold) begin n++; @(negedge clk); #1; end
  endtask

  task automatic op(output int n);
    wr(3'd0, 8'h46); wr(3'd0, 8'hB9); count_hold(n);
  endtask

  task automatic read_at(input logic [7:0] lo, input logic [7:0] e, input string tag);
    int n;
    wr(3'd1, 8'h83); wr(3'd4, lo); wr(3'd5, 8'h00); wr(3'd2, 8'h01);
    op(n); rdchk(3'd5, e, tag);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    for (int s = 1; s < 8; s++) rdchk(3'(s), 8'h00, "R1");
    rdchk(3'd0, 8'hF0, "R3");
    wr(3'd4, 8'h01); rdchk(3'd0, 8'h02, "R3");
    wr(3'd4, 8'h00); rdchk(3'd0, 8'hF0, "R3");
    wr(3'd1, 8'hDF - 8'h20 + 8'h08); rdchk(3'd1, 8'hC7, "R4");
    #1 chk(boot_isp == 1'b1, "R9", boot_isp, 1);
    // read op with wait 7 behaves as 3
    wr(3'd2, 8'h01); wr(3'd4, 8'h05); op(n); chk(n == 6, "R6", n, 6);
    rdchk(3'd5, 8'hFF, "R1");
    // program wait 0
    wr(3'd1, 8'h80); wr(3'd5, 8'hA5); wr(3'd2, 8'h02); op(n); chk(n == 240, "R6", n, 240);
    read_at(8'h05, 8'hA5, "R7");
    // enable low
    wr(3'd1, 8'h03); wr(3'd5, 8'h3C); wr(3'd2, 8'h02); op(n); chk(n == 0, "R5", n, 0);
    read_at(8'h05, 8'hA5, "R5");
    // unlock sequence variants, read mode, enabled
    wr(3'd0, 8'h46); wr(3'd0, 8'h12); wr(3'd0, 8'hB9); count_hold(n); chk(n == 0, "R2", n, 0);
    wr(3'd0, 8'h46); wr(3'd0, 8'h46); wr(3'd0, 8'hB9); count_hold(n); chk(n == 6, "R2", n, 6);
    wr(3'd0, 8'hB9); count_hold(n); chk(n == 0, "R2", n, 0);
    wr(3'd0, 8'h46); wr(3'd2, 8'h01); wr(3'd0, 8'hB9); count_hold(n); chk(n == 6, "R2", n, 6);
    // writes during hold ignored
    wr(3'd4, 8'h15); wr(3'd5, 8'h77); wr(3'd2, 8'h02); wr(3'd1, 8'h80);
    wr(3'd0, 8'h46); wr(3'd0, 8'hB9); wr(3'd5, 8'h11); wr(3'd2, 8'h01);
    count_hold(n); chk(n == 236, "R10", n, 236);
    rdchk(3'd5, 8'h77, "R10"); rdchk(3'd2, 8'h02, "R10");
    // program and read wait codes
    wr(3'd1, 8'h81); op(n); chk(n == 120, "R6", n, 120);
    wr(3'd1, 8'h82); op(n); chk(n == 60, "R6", n, 60);
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h80); op(n); chk(n == 43, "R6", n, 43);
    wr(3'd1, 8'h81); op(n); chk(n == 22, "R6", n, 22);
    wr(3'd1, 8'h82); op(n); chk(n == 11, "R6", n, 11);
    // erase page 0
    wr(3'd4, 8'h05); wr(3'd1, 8'h80); wr(3'd2, 8'h03); op(n); chk(n == 43769, "R6", n, 43769);
    read_at(8'h05, 8'hFF, "R7");
    read_at(8'h15, 8'h77, "R7");
    wr(3'd4, 8'h15); wr(3'd2, 8'h03); op(n); chk(n == 5471, "R6", n, 5471);
    read_at(8'h15, 8'hFF, "R7");
    // high address bit and unsupported modes
    wr(3'd3, 8'hFF); rdchk(3'd3, 8'h01, "R7");
    wr(3'd2, 8'hFC); rdchk(3'd2, 8'h04, "R7"); op(n); chk(n == 0, "R7", n, 0);
    wr(3'd2, 8'h00); op(n); chk(n == 0, "R7", n, 0);
    wr(3'd2, 8'h07); op(n); chk(n == 0, "R7", n, 0);
    // software reset
    wr(3'd2, 8'h01); wr(3'd4, 8'h09); wr(3'd5, 8'h5A); wr(3'd3, 8'h01); wr(3'd1, 8'hC2);
    wr(3'd0, 8'h46);
    wr(3'd1, 8'hE2);
    #1 chk(sys_rst == 1'b1, "R8", sys_rst, 1);
    rdchk(3'd1, 8'hC0, "R9");
    #1 chk(sys_rst == 1'b0, "R8", sys_rst, 0);
    rdchk(3'd2, 8'h00, "R8"); rdchk(3'd3, 8'h00, "R8");
    rdchk(3'd4, 8'h00, "R8"); rdchk(3'd5, 8'h00, "R8");
    wr(3'd2, 8'h01); wr(3'd0, 8'hB9); count_hold(n); chk(n == 0, "R8", n, 0);
    op(n); chk(n == 43, "R8", n, 43);
    // power-up reset clears protected bits
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rdchk(3'd1, 8'h00, "R9");
    #1 chk(boot_isp == 1'b0, "R9", boot_isp, 0);
    read_at(8'h05, 8'hFF, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule